// File: doc/BRIEF.md
# Transmit Queue Start/Stop Controller

This block holds the run state of a bank of transmit DMA queues and exposes it on a simple word-addressed register bus. Software starts a queue by writing a one to its bit in the start register, and asks it to stop by writing a one to its bit in the stop register. A stop does not take effect at once. The queue keeps running until its pending-frame counter has drained to zero, and only then does its run bit fall. Software polls the run bits and the per-queue counters to see when the drain has finished. It then writes zero to the stop register to release every stop request.

The frame datapath sits outside the block and is modelled by two strobes per queue. One strobe says a frame was queued and the other says a frame was sent. A per-queue flush control makes a stopping queue discard its backlog at one frame per clock instead of waiting for sends. A descriptor-pointer register per queue can only be written while that queue is idle. A start request on a queue that still has a stop pending is refused. Each kind of refusal sets its own sticky error bit.

Top module: `txq_ctrl`

## Requirements
- R1: After a synchronous active-low reset, every run bit, stop request, flush bit, pointer, counter and error bit reads zero.
- R2: A bus write to address 0x00 sets the run bit of every queue whose data bit is one and has no stop pending. The change is visible after the write's clock edge. Zero data bits leave their queues unchanged. Address 0x00 reads back the run bits, with queue q at bit q.
- R3: A bus write of a nonzero value to address 0x01 ORs its data bits into the stop requests. A running queue keeps its run bit at one while its counter is nonzero. Address 0x01 reads back the stop requests.
- R4: The 4-bit pending counter of a queue increments on its enqueue strobe and saturates at 15. When the queue is not flushing, the counter decrements on its done strobe and never goes below 0. When both strobes arrive in the same cycle, the counter is unchanged. Address 0x20+q reads the counter of queue q in bits 3:0.
- R5: The run bit of a queue with a stop pending clears at the clock edge where its counter becomes or stays zero. If the counter is already zero, this happens one edge after the stop request is registered.
- R6: A queue with its flush bit set (address 0x02, bit q) and a stop pending decrements its counter by one every cycle while it is nonzero, and it ignores its done strobe.
- R7: A start request on a queue whose stop request is set has no effect, and it sets error bit 0 of address 0x03.
- R8: A write to the descriptor pointer of queue q (address 0x10+q) is refused while that queue runs. The pointer keeps its value and error bit 1 of address 0x03 is set. The write is accepted while the queue is stopped.
- R9: A bus write of the value zero to address 0x01 clears every stop request.
- R10: The error bits at address 0x03 stay set until software writes a one to the same bit position. Writing a zero to a bit leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 6 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| enq_strobe | input | NQ (10) | Per-queue frame-queued pulse |
| done_strobe | input | NQ (10) | Per-queue frame-sent pulse |
| q_enable | output | NQ (10) | Per-queue run bits |

## Verification
The stop handshake is driven in three ways, and each one separates a different way of clearing the run bit. In the first, the stop arrives with frames pending and no flush, so the run bit must survive until the last done strobe. In the second, the stop arrives with the flush bit set, where the counter must fall by exactly one per cycle. In the third, the counter is already empty, where the run bit must fall one edge after the request. Counter patterns cover saturation, simultaneous enqueue and done, and a mix of start writes with some zero bits. Writes that must be refused are checked to leave the run bits and the pointers untouched. A reference model in the bench follows every cycle and compares the run bits and the addressed register against the design.

// File: rtl/txq_pkg.sv
// Shared constants for the transmit queue controller: register map and
// address field split. Assumes a word-addressed bus of ADDR_W bits where
// the upper two bits select a page and the lower bits select an entry.
package txq_pkg;
    localparam int ADDR_W = 6;
    localparam int IDX_W  = 4;
    localparam int PAGE_W = ADDR_W - IDX_W;
    localparam int ERR_W  = 2;

    typedef enum logic [PAGE_W-1:0] {
        PG_CTRL = 2'd0,
        PG_PTR  = 2'd1,
        PG_CNT  = 2'd2,
        PG_NONE = 2'd3
    } page_e;

    localparam logic [ADDR_W-1:0] ADDR_START = 6'h00;
    localparam logic [ADDR_W-1:0] ADDR_STOP  = 6'h01;
    localparam logic [ADDR_W-1:0] ADDR_FLUSH = 6'h02;
    localparam logic [ADDR_W-1:0] ADDR_ERR   = 6'h03;

    localparam int ERR_START = 0;
    localparam int ERR_PTR   = 1;
endpackage

// File: rtl/txq_slot.sv
// One transmit queue: run bit, stop request, flush bit, pending counter
// and descriptor pointer. Assumes at most one bus action per cycle and
// that the decoder has already qualified each request for this queue.
module txq_slot #(
    parameter int PTR_W = 32,
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_req,
    input  logic             stop_set,
    input  logic             stop_clr_all,
    input  logic             flush_we,
    input  logic             flush_val,
    input  logic             ptr_we,
    input  logic [PTR_W-1:0] ptr_val,
    input  logic             enq,
    input  logic             done,
    output logic             run,
    output logic             stop_pend,
    output logic             flush_on,
    output logic [CNT_W-1:0] cnt,
    output logic [PTR_W-1:0] ptr,
    output logic             start_refused,
    output logic             ptr_refused
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    logic             run_q, stop_q, flush_q;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [PTR_W-1:0] ptr_q;
    logic             dec_req;

    // Next counter value: flush replaces done strobes while stopping.
    always_comb begin
        dec_req = (stop_q && flush_q) ? 1'b1 : done;
        cnt_d   = cnt_q;
        if (enq && !dec_req) begin
            if (cnt_q != CNT_MAX) cnt_d = cnt_q + CNT_ONE;
        end else if (!enq && dec_req) begin
            if (cnt_q != '0) cnt_d = cnt_q - CNT_ONE;
        end
    end

    // State update for run bit, stop request, flush bit, counter, pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q   <= 1'b0;
            stop_q  <= 1'b0;
            flush_q <= 1'b0;
            cnt_q   <= '0;
            ptr_q   <= '0;
        end else begin
            if (start_req && !stop_q)           run_q <= 1'b1;
            else if (stop_q && cnt_d == '0)     run_q <= 1'b0;
            if (stop_clr_all)                   stop_q <= 1'b0;
            else if (stop_set)                  stop_q <= 1'b1;
            if (flush_we)                       flush_q <= flush_val;
            if (ptr_we && !run_q)               ptr_q <= ptr_val;
            cnt_q <= cnt_d;
        end
    end

    assign run           = run_q;
    assign stop_pend     = stop_q;
    assign flush_on      = flush_q;
    assign cnt           = cnt_q;
    assign ptr           = ptr_q;
    assign start_refused = start_req && stop_q;
    assign ptr_refused   = ptr_we && run_q;
endmodule

// File: rtl/txq_decode.sv
// Write decoder: turns one bus write into per-queue request vectors.
// Assumes NQ fits in both the entry field and the data word.
module txq_decode
    import txq_pkg::*;
#(
    parameter int NQ     = 10,
    parameter int DATA_W = 32
) (
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [NQ-1:0]     start_req,
    output logic [NQ-1:0]     stop_set,
    output logic              stop_clr_all,
    output logic              flush_we,
    output logic [NQ-1:0]     ptr_we,
    output logic [ERR_W-1:0]  err_clr
);
    logic [PAGE_W-1:0] page;
    logic [IDX_W-1:0]  idx;

    assign page = bus_addr[ADDR_W-1:IDX_W];
    assign idx  = bus_addr[IDX_W-1:0];

    // Control page strobes.
    always_comb begin
        start_req    = (bus_we && bus_addr == ADDR_START) ? bus_wdata[NQ-1:0] : '0;
        stop_clr_all = bus_we && bus_addr == ADDR_STOP && bus_wdata == '0;
        stop_set     = (bus_we && bus_addr == ADDR_STOP) ? bus_wdata[NQ-1:0] : '0;
        flush_we     = bus_we && bus_addr == ADDR_FLUSH;
        err_clr      = (bus_we && bus_addr == ADDR_ERR) ? bus_wdata[ERR_W-1:0] : '0;
    end

    // One pointer write strobe per queue.
    for (genvar q = 0; q < NQ; q++) begin : g_ptr
        assign ptr_we[q] = bus_we && page == PG_PTR && idx == IDX_W'(q);
    end
endmodule

// File: rtl/txq_rdmux.sv
// Read multiplexer: selects the register at the bus address. Unmapped
// addresses and entries beyond NQ read as zero.
module txq_rdmux
    import txq_pkg::*;
#(
    parameter int NQ     = 10,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 4
) (
    input  logic [ADDR_W-1:0]            bus_addr,
    input  logic [NQ-1:0]                run,
    input  logic [NQ-1:0]                stop_pend,
    input  logic [NQ-1:0]                flush_on,
    input  logic [ERR_W-1:0]             err,
    input  logic [NQ-1:0][DATA_W-1:0]    ptr_all,
    input  logic [NQ-1:0][CNT_W-1:0]     cnt_all,
    output logic [DATA_W-1:0]            bus_rdata
);
    logic [PAGE_W-1:0] page;
    logic [IDX_W-1:0]  idx;

    assign page = bus_addr[ADDR_W-1:IDX_W];
    assign idx  = bus_addr[IDX_W-1:0];

    // Page and entry selection.
    always_comb begin
        bus_rdata = '0;
        case (page)
            PG_CTRL: begin
                if (bus_addr == ADDR_START)      bus_rdata[NQ-1:0]    = run;
                else if (bus_addr == ADDR_STOP)  bus_rdata[NQ-1:0]    = stop_pend;
                else if (bus_addr == ADDR_FLUSH) bus_rdata[NQ-1:0]    = flush_on;
                else if (bus_addr == ADDR_ERR)   bus_rdata[ERR_W-1:0] = err;
            end
            PG_PTR: begin
                for (int q = 0; q < NQ; q++)
                    if (idx == IDX_W'(q)) bus_rdata = ptr_all[q];
            end
            PG_CNT: begin
                for (int q = 0; q < NQ; q++)
                    if (idx == IDX_W'(q)) bus_rdata[CNT_W-1:0] = cnt_all[q];
            end
            default: bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/txq_ctrl.sv
// Transmit queue start/stop controller top: NQ queue slots, a write
// decoder, a read multiplexer and the sticky error flags. Stops are
// scheduled and complete only when a queue's pending counter is empty.
module txq_ctrl
    import txq_pkg::*;
#(
    parameter int NQ    = 10,
    parameter int PTR_W = 32,
    parameter int CNT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [5:0]        bus_addr,
    input  logic [PTR_W-1:0]  bus_wdata,
    output logic [PTR_W-1:0]  bus_rdata,
    input  logic [NQ-1:0]     enq_strobe,
    input  logic [NQ-1:0]     done_strobe,
    output logic [NQ-1:0]     q_enable
);
    logic [NQ-1:0]             start_req, stop_set, ptr_we;
    logic                      stop_clr_all, flush_we;
    logic [ERR_W-1:0]          err_clr, err_q;
    logic [NQ-1:0]             stop_pend, flush_en, start_ref, ptr_ref;
    logic [NQ-1:0][CNT_W-1:0]  cnt_all;
    logic [NQ-1:0][PTR_W-1:0]  ptr_all;

    txq_decode #(.NQ(NQ), .DATA_W(PTR_W)) u_dec (
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .start_req(start_req), .stop_set(stop_set), .stop_clr_all(stop_clr_all),
        .flush_we(flush_we), .ptr_we(ptr_we), .err_clr(err_clr)
    );

    for (genvar q = 0; q < NQ; q++) begin : g_slot
        txq_slot #(.PTR_W(PTR_W), .CNT_W(CNT_W)) u_slot (
            .clk(clk), .rst_n(rst_n),
            .start_req(start_req[q]), .stop_set(stop_set[q]),
            .stop_clr_all(stop_clr_all), .flush_we(flush_we),
            .flush_val(bus_wdata[q]), .ptr_we(ptr_we[q]), .ptr_val(bus_wdata),
            .enq(enq_strobe[q]), .done(done_strobe[q]),
            .run(q_enable[q]), .stop_pend(stop_pend[q]), .flush_on(flush_en[q]),
            .cnt(cnt_all[q]), .ptr(ptr_all[q]),
            .start_refused(start_ref[q]), .ptr_refused(ptr_ref[q])
        );
    end

    // Sticky error flags: set on a refusal, cleared by writing a one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q <= '0;
        end else begin
            err_q[ERR_START] <= (err_q[ERR_START] && !err_clr[ERR_START]) || (|start_ref);
            err_q[ERR_PTR]   <= (err_q[ERR_PTR]   && !err_clr[ERR_PTR])   || (|ptr_ref);
        end
    end

    txq_rdmux #(.NQ(NQ), .DATA_W(PTR_W), .CNT_W(CNT_W)) u_rd (
        .bus_addr(bus_addr), .run(q_enable), .stop_pend(stop_pend),
        .flush_on(flush_en), .err(err_q), .ptr_all(ptr_all),
        .cnt_all(cnt_all), .bus_rdata(bus_rdata)
    );
endmodule

// File: rtl/txq_ctrl_chk.sv
// Assertion checker for txq_ctrl, attached by bind below. Observes the
// ports and the per-queue state vectors of the top module.
module txq_ctrl_chk
    import txq_pkg::*;
#(
    parameter int NQ    = 10,
    parameter int PTR_W = 32,
    parameter int CNT_W = 4
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     bus_we,
    input logic [ADDR_W-1:0]        bus_addr,
    input logic [PTR_W-1:0]         bus_wdata,
    input logic [NQ-1:0]            enq_strobe,
    input logic [NQ-1:0]            done_strobe,
    input logic [NQ-1:0]            q_enable,
    input logic [NQ-1:0]            stop_pend,
    input logic [NQ-1:0]            flush_en,
    input logic [NQ-1:0][CNT_W-1:0] cnt_all,
    input logic [NQ-1:0][PTR_W-1:0] ptr_all,
    input logic [ERR_W-1:0]         err_q
);
    for (genvar q = 0; q < NQ; q++) begin : g_q
        assert_run_until_empty_R3: assert property (@(posedge clk) disable iff (!rst_n)
            q_enable[q] |=> (q_enable[q] || cnt_all[q] == '0));

        assert_count_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (!(stop_pend[q] && flush_en[q]) && !enq_strobe[q] && !done_strobe[q]) |=> $stable(cnt_all[q]));

        assert_stop_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (stop_pend[q] && cnt_all[q] == '0 && !enq_strobe[q]) |=> !q_enable[q]);

        assert_flush_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (stop_pend[q] && flush_en[q] && cnt_all[q] != '0 && !enq_strobe[q])
            |=> cnt_all[q] == $past(cnt_all[q]) - CNT_W'(1));

        assert_start_refused_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_we && bus_addr == ADDR_START && bus_wdata[q] && stop_pend[q] && !q_enable[q])
            |=> !q_enable[q]);

        assert_ptr_locked_R8: assert property (@(posedge clk) disable iff (!rst_n)
            q_enable[q] |=> $stable(ptr_all[q]));
    end

    assert_stop_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == ADDR_STOP && bus_wdata == '0) |=> stop_pend == '0);

    assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_we && bus_addr == ADDR_ERR) |=> ((err_q & $past(err_q)) == $past(err_q)));
endmodule

bind txq_ctrl txq_ctrl_chk #(.NQ(NQ), .PTR_W(PTR_W), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .enq_strobe(enq_strobe), .done_strobe(done_strobe),
    .q_enable(q_enable), .stop_pend(stop_pend), .flush_en(flush_en),
    .cnt_all(cnt_all), .ptr_all(ptr_all), .err_q(err_q)
);

// File: tb/txq_ctrl_test.sv
// Bench: behavioural reference model compared every clock plus directed checks.
module txq_ctrl_test;
    localparam int NQ = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [NQ-1:0] enq_strobe = '0;
    logic [NQ-1:0] done_strobe = '0;
    logic [NQ-1:0] q_enable;

    int checks = 0;
    int bad = 0;

    txq_ctrl uut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .enq_strobe(enq_strobe),
        .done_strobe(done_strobe), .q_enable(q_enable)
    );

    always #10 clk = ~clk;

    // Reference model state.
    bit          m_run[NQ], m_stop[NQ], m_flush[NQ];
    int          m_cnt[NQ];
    logic [31:0] m_ptr[NQ];
    bit          m_err0, m_err1;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int q = 0; q < NQ; q++) begin
                m_run[q] = 0; m_stop[q] = 0; m_flush[q] = 0; m_cnt[q] = 0; m_ptr[q] = '0;
            end
            m_err0 = 0; m_err1 = 0;
        end else begin
            bit n_run[NQ], n_stop[NQ], n_flush[NQ];
            int n_cnt[NQ];
            bit e0, e1;
            e0 = m_err0; e1 = m_err1;
            if (bus_we && bus_addr == 6'h03) begin
                if (bus_wdata[0]) e0 = 0;
                if (bus_wdata[1]) e1 = 0;
            end
            for (int q = 0; q < NQ; q++) begin
                bit dreq;
                n_run[q] = m_run[q]; n_stop[q] = m_stop[q]; n_flush[q] = m_flush[q];
                dreq = (m_stop[q] && m_flush[q]) ? 1'b1 : done_strobe[q];
                n_cnt[q] = m_cnt[q];
                if (enq_strobe[q] && !dreq) n_cnt[q] = (m_cnt[q] < 15) ? m_cnt[q] + 1 : 15;
                else if (!enq_strobe[q] && dreq) n_cnt[q] = (m_cnt[q] > 0) ? m_cnt[q] - 1 : 0;
                if (bus_we && bus_addr == 6'h00 && bus_wdata[q]) begin
                    if (m_stop[q]) e0 = 1; else n_run[q] = 1;
                end
                if (m_stop[q] && n_cnt[q] == 0) n_run[q] = 0;
                if (bus_we && bus_addr == 6'h01) begin
                    if (bus_wdata == 0) n_stop[q] = 0;
                    else if (bus_wdata[q]) n_stop[q] = 1;
                end
                if (bus_we && bus_addr == 6'h02) n_flush[q] = bus_wdata[q];
                if (bus_we && bus_addr == 6'(16 + q)) begin
                    if (m_run[q]) e1 = 1; else m_ptr[q] = bus_wdata;
                end
            end
            for (int q = 0; q < NQ; q++) begin
                m_run[q] = n_run[q]; m_stop[q] = n_stop[q];
                m_flush[q] = n_flush[q]; m_cnt[q] = n_cnt[q];
            end
            m_err0 = e0; m_err1 = e1;
        end
    end

    function automatic logic [31:0] m_vec(input int sel);
        logic [31:0] v = '0;
        for (int q = 0; q < NQ; q++)
            v[q] = (sel == 0) ? m_run[q] : (sel == 1) ? m_stop[q] : m_flush[q];
        return v;
    endfunction

    function automatic logic [31:0] m_read(input logic [5:0] a);
        if (a == 6'h00) return m_vec(0);
        if (a == 6'h01) return m_vec(1);
        if (a == 6'h02) return m_vec(2);
        if (a == 6'h03) return {30'd0, m_err1, m_err0};
        if (a[5:4] == 2'd1 && int'(a[3:0]) < NQ) return m_ptr[a[3:0]];
        if (a[5:4] == 2'd2 && int'(a[3:0]) < NQ) return 32'(m_cnt[a[3:0]]);
        return '0;
    endfunction

    // Per-cycle comparison of run bits and addressed register against the model.
    always @(posedge clk) begin
        #2;
        checks++;
        if (q_enable !== m_vec(0)[NQ-1:0]) begin
            bad++;
            $display("FAIL R3 per-cycle run bits act=%h exp=%h", q_enable, m_vec(0)[NQ-1:0]);
        end
        checks++;
        if (bus_rdata !== m_read(bus_addr)) begin
            bad++;
            $display("FAIL R5 per-cycle read addr=%h act=%h exp=%h", bus_addr, bus_rdata, m_read(bus_addr));
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] v);
        @(negedge clk);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    task automatic pulse(input logic [NQ-1:0] e, input logic [NQ-1:0] d, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            enq_strobe = e; done_strobe = d;
            @(negedge clk);
            enq_strobe = '0; done_strobe = '0;
        end
    endtask

    initial begin
        #(20 * 100000);
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        rd(6'h00, v); chk("R1 run bits after reset", v, 32'h0);
        rd(6'h01, v); chk("R1 stop after reset", v, 32'h0);
        rd(6'h10, v); chk("R1 pointer 0 after reset", v, 32'h0);
        rd(6'h20, v); chk("R1 counter 0 after reset", v, 32'h0);
        rd(6'h03, v); chk("R1 errors after reset", v, 32'h0);

        wr(6'h10, 32'hA5A5_0001);
        rd(6'h10, v); chk("R8 pointer write accepted while stopped", v, 32'hA5A5_0001);

        pulse(10'b00_0000_0001, '0, 3);
        pulse(10'b00_0000_1000, '0, 2);
        rd(6'h20, v); chk("R4 counter after 3 enqueues", v, 32'd3);

        wr(6'h00, 32'h1);
        rd(6'h00, v); chk("R2 start queue 0", v, 32'h1);
        wr(6'h00, 32'h8);
        rd(6'h00, v); chk("R2 zero bits leave queue 0 running", v, 32'h9);

        wr(6'h10, 32'h1234_5678);
        rd(6'h10, v); chk("R8 pointer locked while running", v, 32'hA5A5_0001);
        rd(6'h03, v); chk("R8 pointer refusal flag", v, 32'h2);
        wr(6'h03, 32'h1);
        rd(6'h03, v); chk("R10 zero bit write keeps flag", v, 32'h2);
        wr(6'h03, 32'h2);
        rd(6'h03, v); chk("R10 write one clears flag", v, 32'h0);

        wr(6'h01, 32'h1);
        rd(6'h00, v); chk("R3 run held while frames pending", v, 32'h9);
        pulse(10'b00_0000_0000, 10'b00_0000_0001, 2);
        rd(6'h20, v); chk("R4 counter after 2 done strobes", v, 32'd1);
        rd(6'h00, v); chk("R3 run held with one frame left", v, 32'h9);
        pulse('0, 10'b00_0000_0001, 1);
        rd(6'h00, v); chk("R5 run clears when drained", v, 32'h8);

        wr(6'h00, 32'h1);
        rd(6'h00, v); chk("R7 start refused during stop", v, 32'h8);
        rd(6'h03, v); chk("R7 start refusal flag", v, 32'h1);

        wr(6'h01, 32'h0);
        rd(6'h01, v); chk("R9 zero write clears stops", v, 32'h0);
        wr(6'h00, 32'h1);
        rd(6'h00, v); chk("R2 restart after stop released", v, 32'h9);
        wr(6'h03, 32'h3);

        pulse(10'b00_0010_0000, '0, 20);
        rd(6'h25, v); chk("R4 counter saturates at 15", v, 32'd15);
        pulse('0, 10'b00_0010_0000, 1);
        pulse(10'b00_0010_0000, 10'b00_0010_0000, 1);
        rd(6'h25, v); chk("R4 simultaneous enqueue and done", v, 32'd14);

        wr(6'h02, 32'h20);
        wr(6'h00, 32'h20);
        rd(6'h00, v); chk("R2 start queue 5", v, 32'h29);
        wr(6'h01, 32'h20);
        rd(6'h25, v); chk("R6 flush one per cycle", v, 32'd13);
        repeat (16) @(negedge clk);
        rd(6'h25, v); chk("R6 flush drains counter", v, 32'd0);
        rd(6'h00, v); chk("R5 run clears after flush", v, 32'h9);

        wr(6'h01, 32'h0);
        wr(6'h01, 32'h1);
        rd(6'h00, v); chk("R5 empty queue stops one edge later", v, 32'h8);
        wr(6'h01, 32'h8);
        rd(6'h01, v); chk("R3 stop requests accumulate", v, 32'h9);
        rd(6'h00, v); chk("R3 queue 3 held with frames pending", v, 32'h8);

        repeat (2) @(negedge clk);
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule